// File: doc/BRIEF.md
# Octal DAC Register File Controller

This block sits between a serial word receiver and eight 12-bit digital-to-analogue channels. Each accepted 16-bit command word carries a 4-bit address in its upper bits and a 12-bit payload in its lower bits. The address selects one of eight channel input registers, a global control register, a pair control register, a preset register, a reserved slot, or one of four pair slots. A pair slot writes the payload to the even channel of the pair and the bitwise inverse of that payload to the odd channel, which gives a differential output from a single command.

Channel input registers feed a clocked output stage that is gated by an active-low load input. An asynchronous active-low preset input forces every channel output to the preset register value. When the global control register selects signed input, channel payloads are turned into offset binary by flipping their top bit before they are stored.

Commands pass through a two-state controller. ST_IDLE waits for a command. An accepted command moves the controller to ST_COMMIT, and in that state the captured word is applied to the register bank. If another command arrives during ST_COMMIT, the controller stays in ST_COMMIT; otherwise it returns to ST_IDLE.

Top module: `octdac_regfile`

## Requirements
- R1: The address is bits [15:12] of the word and the data is bits [11:0]. Addresses 0 to 7 write the input register of channel 0 to 7 (A to H). Channel n is driven on `dac_codes[12n+11:12n]`.
- R2: Address 12+p (p = 0..3) writes the converted data to channel 2p and its bitwise inverse to channel 2p+1. For example, word 0xCFFF gives channel 0 the code 0xFFF and channel 1 the code 0x000.
- R3: A write to address 11 changes no register and no output.
- R4: Address 8 sets the global controls: bit 4 drives `global_pd`, bit 3 drives `chain_en` and bit 0 selects signed input.
- R5: Address 9 sets the pair controls. Bits 7:4 drive `pair_pd[3:0]` and bits 3:0 drive `pair_fast[3:0]`. Index 0 is pair AB and index 3 is pair GH, and a 1 in `pair_fast` means fast mode.
- R6: On each clock edge while `load_n` is low, every channel output stage copies its input register. While `load_n` is high, the outputs hold their values.
- R7: While `preset_n` is low, every channel output shows the preset register (address 10) at once, without waiting for a clock edge. If the preset register was never written, that value is 0.
- R8: In signed mode, writes to addresses 0 to 7 and 12 to 15 store the data with bit 11 inverted, so signed zero becomes 0x800. Pair slots invert this converted value for the odd channel. The preset register always stores the raw data.
- R9: Asynchronous reset clears every register to 0: channel codes, controls and preset.
- R10: A word accepted on clock edge k updates its register on edge k+1 and the channel output on edge k+2. Commands on consecutive cycles are all applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | The command word is present this cycle |
| cmd_word | input | 16 | Command word: address in [15:12], data in [11:0] |
| load_n | input | 1 | Active-low transfer enable for the output stage |
| preset_n | input | 1 | Asynchronous active-low preset override |
| dac_codes | output | 96 | Eight 12-bit channel codes; channel n is at [12n+11:12n] |
| pair_pd | output | 4 | Power-down for each channel pair |
| pair_fast | output | 4 | Fast-mode select for each channel pair |
| global_pd | output | 1 | Whole-block power-down |
| chain_en | output | 1 | Daisy-chain output enable |

## Verification
The vector table applies direct writes to the first and last channels and pair writes with all-ones and with alternating-bit payloads. These cases separate a correct complement from a copied value and show whether the pair index maps to the correct even channel. A reserved write follows, and the bench confirms that earlier codes survive it. Directed cases then cover signed mode with zero, with the extreme positive value and in pair form, which exposes a conversion applied in the wrong order. Further cases show that the preset register stays raw under signed mode, check the one-edge gap between register update and output, and send back-to-back commands, held loads and asynchronous preset and reset.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } cmd_state_e;

    // Bit positions inside the global control payload
    localparam int unsigned GB_PD    = 4;
    localparam int unsigned GB_CHAIN = 3;
    localparam int unsigned GB_TWOS  = 0;

endpackage

// File: rtl/octdac_cmd_fsm.sv
module octdac_cmd_fsm
    import octdac_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [ADDR_W+CODE_W-1:0] cmd_word,
    input  logic                     twos_mode,
    output logic [NUM_CH-1:0]        code_we,
    output logic [NUM_CH*CODE_W-1:0] code_wdata,
    output logic                     gctl_we,
    output logic                     pctl_we,
    output logic                     preset_we,
    output logic [CODE_W-1:0]        raw_data
);

    localparam int unsigned WORD_W = ADDR_W + CODE_W;
    localparam logic [ADDR_W-1:0] A_GCTL      = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_PCTL      = ADDR_W'(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] A_PRESET    = ADDR_W'(NUM_CH + 2);
    localparam logic [ADDR_W-1:0] A_PAIR_BASE = ADDR_W'(NUM_CH + 4);

    cmd_state_e          state_q, state_d;
    logic [WORD_W-1:0]   word_q;
    logic [ADDR_W-1:0]   addr;
    logic [ADDR_W-1:0]   pair_idx;
    logic [CODE_W-1:0]   conv;
    logic                commit;
    logic                pair_wr;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cmd_valid ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = cmd_valid ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_valid) begin
                word_q <= cmd_word;
            end
        end
    end

    // Decode outputs
    always_comb begin
        addr      = word_q[WORD_W-1:CODE_W];
        raw_data  = word_q[CODE_W-1:0];
        conv      = raw_data ^ {twos_mode, {(CODE_W-1){1'b0}}};
        commit    = (state_q == ST_COMMIT);
        pair_wr   = commit && (addr >= A_PAIR_BASE);
        pair_idx  = addr - A_PAIR_BASE;
        gctl_we   = commit && (addr == A_GCTL);
        pctl_we   = commit && (addr == A_PCTL);
        preset_we = commit && (addr == A_PRESET);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign code_we[c] = (commit && (addr == ADDR_W'(c))) ||
                            (pair_wr && (pair_idx == ADDR_W'(c / 2)));
        if (c % 2 == 1) begin : g_odd
            assign code_wdata[c*CODE_W +: CODE_W] = pair_wr ? ~conv : conv;
        end else begin : g_even
            assign code_wdata[c*CODE_W +: CODE_W] = conv;
        end
    end

endmodule

// File: rtl/octdac_ctrl_regs.sv
module octdac_ctrl_regs
    import octdac_pkg::*;
#(
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned NUM_PAIR = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gctl_we,
    input  logic                pctl_we,
    input  logic                preset_we,
    input  logic [CODE_W-1:0]   wdata,
    output logic                global_pd,
    output logic                chain_en,
    output logic                twos_mode,
    output logic [NUM_PAIR-1:0] pair_pd,
    output logic [NUM_PAIR-1:0] pair_fast,
    output logic [CODE_W-1:0]   preset_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            global_pd <= 1'b0;
            chain_en  <= 1'b0;
            twos_mode <= 1'b0;
        end else if (gctl_we) begin
            global_pd <= wdata[GB_PD];
            chain_en  <= wdata[GB_CHAIN];
            twos_mode <= wdata[GB_TWOS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_pd   <= '0;
            pair_fast <= '0;
        end else if (pctl_we) begin
            pair_pd   <= wdata[2*NUM_PAIR-1:NUM_PAIR];
            pair_fast <= wdata[NUM_PAIR-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
        end else if (preset_we) begin
            preset_q <= wdata;
        end
    end

endmodule

// File: rtl/octdac_code_bank.sv
module octdac_code_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        code_we,
    input  logic [NUM_CH*CODE_W-1:0] code_wdata,
    input  logic                     load_n,
    input  logic                     preset_n,
    input  logic [CODE_W-1:0]        preset_q,
    output logic [NUM_CH*CODE_W-1:0] code_q,
    output logic [NUM_CH*CODE_W-1:0] latch_q,
    output logic [NUM_CH*CODE_W-1:0] dac_codes
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[c*CODE_W +: CODE_W] <= '0;
            end else if (code_we[c]) begin
                code_q[c*CODE_W +: CODE_W] <= code_wdata[c*CODE_W +: CODE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                latch_q[c*CODE_W +: CODE_W] <= '0;
            end else if (!load_n) begin
                latch_q[c*CODE_W +: CODE_W] <= code_q[c*CODE_W +: CODE_W];
            end
        end

        assign dac_codes[c*CODE_W +: CODE_W] =
            preset_n ? latch_q[c*CODE_W +: CODE_W] : preset_q;
    end

endmodule

// File: rtl/octdac_regfile.sv
module octdac_regfile #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [ADDR_W+CODE_W-1:0]   cmd_word,
    input  logic                       load_n,
    input  logic                       preset_n,
    output logic [NUM_CH*CODE_W-1:0]   dac_codes,
    output logic [NUM_CH/2-1:0]        pair_pd,
    output logic [NUM_CH/2-1:0]        pair_fast,
    output logic                       global_pd,
    output logic                       chain_en
);

    localparam int unsigned NUM_PAIR = NUM_CH / 2;

    logic [NUM_CH-1:0]        code_we;
    logic [NUM_CH*CODE_W-1:0] code_wdata;
    logic [NUM_CH*CODE_W-1:0] code_q;
    logic [NUM_CH*CODE_W-1:0] latch_q;
    logic [CODE_W-1:0]        raw_data;
    logic [CODE_W-1:0]        preset_q;
    logic                     gctl_we;
    logic                     pctl_we;
    logic                     preset_we;
    logic                     twos_mode;

    octdac_cmd_fsm #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .twos_mode  (twos_mode),
        .code_we    (code_we),
        .code_wdata (code_wdata),
        .gctl_we    (gctl_we),
        .pctl_we    (pctl_we),
        .preset_we  (preset_we),
        .raw_data   (raw_data)
    );

    octdac_ctrl_regs #(
        .CODE_W   (CODE_W),
        .NUM_PAIR (NUM_PAIR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gctl_we   (gctl_we),
        .pctl_we   (pctl_we),
        .preset_we (preset_we),
        .wdata     (raw_data),
        .global_pd (global_pd),
        .chain_en  (chain_en),
        .twos_mode (twos_mode),
        .pair_pd   (pair_pd),
        .pair_fast (pair_fast),
        .preset_q  (preset_q)
    );

    octdac_code_bank #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_we    (code_we),
        .code_wdata (code_wdata),
        .load_n     (load_n),
        .preset_n   (preset_n),
        .preset_q   (preset_q),
        .code_q     (code_q),
        .latch_q    (latch_q),
        .dac_codes  (dac_codes)
    );

endmodule

// File: rtl/octdac_regfile_chk.sv
module octdac_regfile_chk #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_n,
    input logic                     preset_n,
    input logic [NUM_CH-1:0]        code_we,
    input logic [NUM_CH*CODE_W-1:0] code_q,
    input logic [NUM_CH*CODE_W-1:0] latch_q,
    input logic [NUM_CH*CODE_W-1:0] dac_codes,
    input logic [CODE_W-1:0]        preset_q,
    input logic                     gctl_we,
    input logic                     global_pd,
    input logic                     chain_en
);

    AST_WE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(code_we) <= 2); // R2

    for (genvar p = 0; p < NUM_CH / 2; p++) begin : g_pair
        AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
            (code_we[2*p] && code_we[2*p+1]) |=>
            (code_q[2*p*CODE_W +: CODE_W] == ~code_q[(2*p+1)*CODE_W +: CODE_W])); // R2
    end

    AST_GCTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gctl_we |=> $stable({global_pd, chain_en})); // R4

    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(latch_q)); // R6

    AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (latch_q == $past(code_q))); // R6

    AST_PRESET_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |-> (dac_codes == {NUM_CH{preset_q}})); // R7

endmodule

bind octdac_regfile octdac_regfile_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .preset_n  (preset_n),
    .code_we   (code_we),
    .code_q    (code_q),
    .latch_q   (latch_q),
    .dac_codes (dac_codes),
    .preset_q  (preset_q),
    .gctl_we   (gctl_we),
    .global_pd (global_pd),
    .chain_en  (chain_en)
);

// File: tb/octdac_regfile_test.sv
`timescale 1ns/1ps
module octdac_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        load_n = 1'b0;
    logic        preset_n = 1'b1;
    logic [95:0] dac_codes;
    logic [3:0]  pair_pd;
    logic [3:0]  pair_fast;
    logic        global_pd;
    logic        chain_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    octdac_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .load_n    (load_n),
        .preset_n  (preset_n),
        .dac_codes (dac_codes),
        .pair_pd   (pair_pd),
        .pair_fast (pair_fast),
        .global_pd (global_pd),
        .chain_en  (chain_en)
    );

    // {word, channel a, expected a, channel b, expected b}
    localparam logic [47:0] VEC [7] = '{
        {16'h0ABC, 4'd0, 12'hABC, 4'd1, 12'h000},
        {16'h7123, 4'd7, 12'h123, 4'd6, 12'h000},
        {16'hCFFF, 4'd0, 12'hFFF, 4'd1, 12'h000},
        {16'hD5A5, 4'd2, 12'h5A5, 4'd3, 12'hA5A},
        {16'h3111, 4'd3, 12'h111, 4'd2, 12'h5A5},
        {16'hF800, 4'd6, 12'h800, 4'd7, 12'h7FF},
        {16'hB777, 4'd7, 12'h7FF, 4'd0, 12'hFFF}
    };

    function automatic logic [11:0] ch(input int idx);
        return dac_codes[idx*12 +: 12];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Word in, then two more edges: output stage updated
    task automatic write(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset codes", {31'd0, dac_codes == '0}, 32'd1);
        check("R9 reset ctrl", {22'd0, pair_pd, pair_fast, global_pd, chain_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 7; i++) begin
            logic [47:0] v;
            v = VEC[i];
            write(v[47:32]);
            check($sformatf("R1 R2 R3 vec%0d chA", i), {20'd0, ch(int'(v[31:28]))}, {20'd0, v[27:16]});
            check($sformatf("R1 R2 R3 vec%0d chB", i), {20'd0, ch(int'(v[15:12]))}, {20'd0, v[11:0]});
        end
        check("R3 ctrl untouched", {22'd0, pair_pd, pair_fast, global_pd, chain_en}, 32'd0);

        // Preset never written: zero
        @(negedge clk);
        preset_n = 1'b0;
        #1;
        check("R7 unwritten preset ch0", {20'd0, ch(0)}, 32'h0);
        check("R7 unwritten preset ch7", {20'd0, ch(7)}, 32'h0);
        preset_n = 1'b1;
        #1;
        check("R7 release", {20'd0, ch(0)}, 32'hFFF);

        write(16'h90A5);
        check("R5 pair_pd", {28'd0, pair_pd}, 32'hA);
        check("R5 pair_fast", {28'd0, pair_fast}, 32'h5);

        // Load held high
        load_n = 1'b1;
        write(16'h2333);
        check("R6 hold while high", {20'd0, ch(2)}, 32'h5A5);
        load_n = 1'b0;
        @(negedge clk);
        check("R6 transfer when low", {20'd0, ch(2)}, 32'h333);

        write(16'h8019);
        check("R4 global_pd", {31'd0, global_pd}, 32'd1);
        check("R4 chain_en", {31'd0, chain_en}, 32'd1);

        write(16'h0000);
        check("R8 signed zero", {20'd0, ch(0)}, 32'h800);
        write(16'hC7FF);
        check("R8 pair even", {20'd0, ch(0)}, 32'hFFF);
        check("R8 pair odd", {20'd0, ch(1)}, 32'h000);
        write(16'h1FFF);
        check("R8 signed minus one", {20'd0, ch(1)}, 32'h7FF);

        write(16'hA456);
        preset_n = 1'b0;
        #1;
        check("R7 R8 preset raw ch3", {20'd0, ch(3)}, 32'h456);
        check("R7 preset ch0", {20'd0, ch(0)}, 32'h456);
        preset_n = 1'b1;
        #1;
        check("R7 preset released", {20'd0, ch(0)}, 32'hFFF);

        // Latency: output one edge after register
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = 16'h6ABC;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R10 not yet", {20'd0, ch(6)}, 32'h800);
        @(negedge clk);
        check("R10 after two edges", {20'd0, ch(6)}, 32'h2BC);

        // Back-to-back commands
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = 16'h4111;
        @(negedge clk);
        cmd_word  = 16'h5222;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 back-to-back first", {20'd0, ch(4)}, 32'h911);
        check("R10 back-to-back second", {20'd0, ch(5)}, 32'hA22);

        write(16'h8000);
        write(16'h0000);
        check("R8 binary zero", {20'd0, ch(0)}, 32'h000);
        check("R4 cleared", {30'd0, global_pd, chain_en}, 32'd0);

        rst_n = 1'b0;
        #1;
        check("R9 async reset codes", {31'd0, dac_codes == '0}, 32'd1);
        check("R9 async reset pairs", {24'd0, pair_pd, pair_fast}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule